// File: doc/BRIEF.md
# Timer-Paced Serial Shifter

This block is a 32-bit serial shift register paired with a single-entry holding buffer. An external timer supplies the pacing: a shift strobe moves one bit, a store strobe either moves the buffer into the shift register (transmit) or the shift register into the buffer (the two receive modes), and two further strobes mark the positions of a start bit and a stop bit on the serial input. Software talks to the block through a small register port with three addresses: control, flags and buffer.

Three modes exist. Transmit sends buffer contents out least significant bit first. Receive captures incoming bits and hands each completed word to software. Match store also captures bits, but keeps a word only when its upper half equals a software pattern in the bits left open by a mask. A status flag tells software when the buffer needs service. A sticky error flag, cleared by writing 1, records underrun, overrun and framing mismatches. Both flags feed an interrupt output, and the status flag also feeds a DMA request.

Top module: `tmr_shift_unit`

## Requirements
- R1: After reset the control register, both flags, irq and dma_req are 0, and serial_out is 1.
- R2: Control register (address 0) holds mode in bits [1:0] (0 idle, 1 transmit, 2 receive, 3 match store), start check enable in bit 2, stop check enable in bit 3, status interrupt enable in bit 4, error interrupt enable in bit 5 and DMA enable in bit 6. A control write that changes the mode empties the buffer and leaves the status flag at 1 if the new mode is transmit, otherwise at 0.
- R3: In transmit mode, writing the buffer (address 2) marks it full and clears the status flag (bit 0 of address 1). A store strobe with a full buffer copies it into the shift register, empties it and sets the status flag. serial_out is bit 0 of the shift register, and each shift strobe moves it one place toward bit 0, filling with 1.
- R4: In transmit mode, a store strobe with an empty buffer sets the error flag (bit 1 of address 1) and leaves the shift register unchanged.
- R5: Writing the flags address with bit 1 set clears the error flag, and writing 0 there leaves it unchanged. If a hardware error event occurs in the same cycle as the clear, the flag ends up set.
- R6: In receive mode, each shift strobe moves serial_in into bit 31 and shifts the register toward bit 0. A store strobe with an empty buffer copies the register into the buffer and sets the status flag. Reading the buffer returns that word, empties the buffer and clears the status flag.
- R7: In receive mode, a store strobe while the buffer is full and not being read sets the error flag and keeps the old buffer word.
- R8: In match store mode, the buffer's upper 16 bits are the pattern and its lower 16 bits are the mask. A store strobe stores the shift register only if its bits [31:16] equal the pattern at every position where the mask bit is 0. On a mismatch neither the buffer nor the status flag changes.
- R9: In the receive modes, with the start check enabled, serial_in equal to 1 on a start strobe sets the error flag. With the stop check enabled, serial_in equal to 0 on a stop strobe sets it. With the checks disabled, neither strobe has an effect.
- R10: irq is (status AND status interrupt enable) OR (error AND error interrupt enable). dma_req is status AND DMA enable.
- R11: In transmit mode, a buffer write in the same cycle as a store strobe leaves the buffer full with the written word and the status flag at 0. The shift register takes the previous buffer word if there was one; otherwise the error flag is set.
- R12: In the receive modes, a store strobe in the same cycle as a buffer read succeeds. The read returns the old word, and the buffer then holds the new word with the status flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a buffer read has side effects) |
| reg_addr | input | 2 | Register address: 0 control, 1 flags, 2 buffer |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| shift_evt | input | 1 | Timer shift strobe |
| store_evt | input | 1 | Timer store/load strobe |
| start_evt | input | 1 | Timer strobe at the start bit position |
| stop_evt | input | 1 | Timer strobe at the stop bit position |
| serial_in | input | 1 | Serial data input |
| serial_out | output | 1 | Serial data output |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench drives the colliding cases: a buffer write and a load strobe in the same cycle, with and without a word already waiting; a buffer read and a store strobe together; and an error clear colliding with a fresh underrun. A design that gave the wrong side priority would lose a transmit word, report a spurious overrun, or drop an error event. A mask test stores a word that differs from the pattern only under the mask, and a second test sends the same word with the mask cleared. This catches an inverted mask sense or a comparison against the wrong half of the register. An underrun in the middle of a word checks that the serial output keeps going, which exposes a design that reloads stale buffer contents.

// File: rtl/tmr_shift_unit.sv
module tmr_shift_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         shift_evt,
  input  logic         store_evt,
  input  logic         start_evt,
  input  logic         stop_evt,
  input  logic         serial_in,
  output logic         serial_out,
  output logic         irq,
  output logic         dma_req
);
  localparam int HW = W / 2;
  localparam logic [1:0] M_TX = 2'd1, M_RX = 2'd2, M_MATCH = 2'd3;

  logic [1:0]   mode;
  logic         start_en, stop_en, stat_ie, err_ie, dma_en;
  logic [W-1:0] shreg, bufr;
  logic         buf_full, stat, err;

  wire ctrl_wr  = reg_wr && reg_addr == 2'd0;
  wire flag_wr  = reg_wr && reg_addr == 2'd1;
  wire buf_wr   = reg_wr && reg_addr == 2'd2;
  wire buf_rd   = reg_rd && reg_addr == 2'd2;
  wire mode_chg = ctrl_wr && reg_wdata[1:0] != mode;
  wire is_tx    = mode == M_TX;
  wire rx_like  = mode[1];

  wire match_hit = ((shreg[W-1:HW] ^ bufr[W-1:HW]) & ~bufr[HW-1:0]) == '0;
  wire keep_word = (mode == M_RX) || match_hit;
  wire room      = !buf_full || buf_rd;

  wire do_load  = is_tx && store_evt && buf_full;
  wire underrun = is_tx && store_evt && !buf_full;
  wire do_store = rx_like && store_evt && keep_word && room;
  wire overrun  = rx_like && store_evt && keep_word && !room;
  wire bit_err  = rx_like && ((start_evt && start_en && serial_in) ||
                              (stop_evt && stop_en && !serial_in));
  wire err_set  = underrun || overrun || bit_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {dma_en, err_ie, stat_ie, stop_en, start_en, mode} <= '0;
    end else if (ctrl_wr) begin
      {dma_en, err_ie, stat_ie, stop_en, start_en, mode} <= reg_wdata[6:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    shreg <= '0;
    else if (do_load)              shreg <= bufr;
    else if (shift_evt && is_tx)   shreg <= {1'b1, shreg[W-1:1]};
    else if (shift_evt && rx_like) shreg <= {serial_in, shreg[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bufr <= '0;
    else if (buf_wr)   bufr <= reg_wdata;
    else if (do_store) bufr <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      stat     <= 1'b0;
    end else if (mode_chg) begin
      buf_full <= 1'b0;
      stat     <= reg_wdata[1:0] == M_TX;
    end else if (is_tx) begin
      if (buf_wr) begin
        buf_full <= 1'b1;
        stat     <= 1'b0;
      end else if (do_load) begin
        buf_full <= 1'b0;
        stat     <= 1'b1;
      end
    end else if (rx_like) begin
      if (do_store) begin
        buf_full <= 1'b1;
        stat     <= 1'b1;
      end else if (buf_rd) begin
        buf_full <= 1'b0;
        stat     <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        err <= 1'b0;
    else if (err_set)                  err <= 1'b1;
    else if (flag_wr && reg_wdata[1])  err <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[6:0] = {dma_en, err_ie, stat_ie, stop_en, start_en, mode};
      2'd1: reg_rdata[1:0] = {err, stat};
      2'd2: reg_rdata      = bufr;
      default: reg_rdata   = '0;
    endcase
  end

  assign serial_out = is_tx ? shreg[0] : 1'b1;
  assign irq        = (stat && stat_ie) || (err && err_ie);
  assign dma_req    = stat && dma_en;
endmodule

// File: rtl/tmr_shift_unit_chk.sv
module tmr_shift_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         store_evt,
  input logic         buf_full,
  input logic         stat,
  input logic         err,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] bufr,
  input logic         match_hit
);
  wire ctrl_wr = reg_wr && reg_addr == 2'd0;
  wire buf_wr  = reg_wr && reg_addr == 2'd2;

  AST_UNDERRUN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && store_evt && !buf_full) |=> err); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(reg_wr && reg_addr == 2'd1 && reg_wdata[1])) |=> err); // R5

  AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && buf_wr) |=> (!stat && buf_full)); // R11

  AST_RX_STAT_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !store_evt && !ctrl_wr) |=> !$rose(stat)); // R6

  AST_MATCH_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && store_evt && !match_hit && !buf_wr && !ctrl_wr)
      |=> ($stable(bufr) && !$rose(stat))); // R8
endmodule

bind tmr_shift_unit tmr_shift_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .store_evt(store_evt),
  .buf_full(buf_full), .stat(stat), .err(err), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .bufr(bufr),
  .match_hit(match_hit)
);

// File: tb/tmr_shift_unit_tb.sv
module tmr_shift_unit_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic shift_evt = 0, store_evt = 0, start_evt = 0, stop_evt = 0;
  logic serial_in = 0;
  logic serial_out, irq, dma_req;

  int n_tests = 0, n_fail = 0, cycles = 0;

  always #4 clk = ~clk;

  tmr_shift_unit #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .shift_evt(shift_evt), .store_evt(store_evt), .start_evt(start_evt),
    .stop_evt(stop_evt), .serial_in(serial_in), .serial_out(serial_out),
    .irq(irq), .dma_req(dma_req)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    tick();
    reg_rd = 0;
  endtask

  task automatic flags(output logic [W-1:0] d);
    rd(2'd1, d);
  endtask

  task automatic store();
    store_evt = 1; tick(); store_evt = 0;
  endtask

  task automatic shift1();
    shift_evt = 1; tick(); shift_evt = 0;
  endtask

  task automatic shift_word(input logic [W-1:0] d);
    for (int i = 0; i < W; i++) begin
      serial_in = d[i];
      shift1();
    end
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 0);
    flags(v);    check("R1 flags", v, 0);
    check("R1 irq", irq, 0);
    check("R1 dma", dma_req, 0);
    check("R1 serial_out", serial_out, 1);
  endtask

  task automatic t_transmit();
    logic [W-1:0] v;
    logic [W-1:0] d = 32'hA5A5_0F0F;
    wr(2'd0, 1);
    flags(v); check("R2 enter tx stat", v, 1);
    wr(2'd2, d);
    flags(v); check("R3 write clears stat", v, 0);
    store();
    flags(v); check("R3 load sets stat", v, 1);
    for (int i = 0; i < 4; i++) begin
      check("R3 serial bit", serial_out, d[i]);
      shift1();
    end
    check("R3 serial bit4", serial_out, 0);
    store();
    flags(v); check("R4 underrun err", v, 3);
    check("R4 shifter unchanged", serial_out, 0);
    shift1();
    check("R4 shifting continues", serial_out, d[5]);
    wr(2'd1, 0);
    flags(v); check("R5 write0 keeps err", v, 3);
    wr(2'd1, 2);
    flags(v); check("R5 w1c clears err", v, 1);
  endtask

  task automatic t_collide_tx();
    logic [W-1:0] v;
    reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h0000_00F0; store_evt = 1;
    tick();
    reg_wr = 0; store_evt = 0;
    flags(v); check("R11 empty collide err set stat clear", v, 2);
    store();
    flags(v); check("R11 written word loadable", v[0], 1);
    check("R11 loaded bit0", serial_out, 0);
    for (int i = 0; i < 4; i++) shift1();
    check("R11 loaded bit4", serial_out, 1);
    wr(2'd2, 32'h3);
    reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h5; store_evt = 1;
    tick();
    reg_wr = 0; store_evt = 0;
    flags(v); check("R11 full collide stat clear", v[0], 0);
    shift1();
    check("R11 old word loaded", serial_out, 1);
    store();
    check("R11 new word kept bit0", serial_out, 1);
    shift1();
    check("R11 new word kept bit1", serial_out, 0);
    wr(2'd1, 2);
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 2; store_evt = 1;
    tick();
    reg_wr = 0; store_evt = 0;
    flags(v); check("R5 set beats clear", v[1], 1);
  endtask

  task automatic t_irq_dma();
    wr(2'd0, 32'h11);
    check("R10 irq via stat", irq, 1);
    wr(2'd1, 2);
    wr(2'd0, 32'h21);
    check("R10 irq err only, err clear", irq, 0);
    wr(2'd0, 32'h41);
    check("R10 dma", dma_req, 1);
    check("R10 no irq when disabled", irq, 0);
    store();
    wr(2'd0, 32'h21);
    check("R10 irq via err", irq, 1);
    check("R10 dma disabled", dma_req, 0);
  endtask

  task automatic t_receive();
    logic [W-1:0] v;
    wr(2'd0, 2);
    flags(v); check("R2 enter rx stat clear", v[0], 0);
    wr(2'd1, 2);
    shift_word(32'h1234_5678);
    flags(v); check("R6 no store no stat", v, 0);
    store();
    flags(v); check("R6 store sets stat", v, 1);
    rd(2'd2, v); check("R6 read word", v, 32'h1234_5678);
    flags(v); check("R6 read clears stat", v, 0);
    shift_word(32'hCAFE_F00D); store();
    shift_word(32'h0BAD_BEEF); store();
    flags(v); check("R7 overrun err", v, 3);
    rd(2'd2, v); check("R7 old word kept", v, 32'hCAFE_F00D);
    wr(2'd1, 2);
    shift_word(32'h1111_1111); store();
    shift_word(32'h2222_2222);
    reg_rd = 1; reg_addr = 2'd2; store_evt = 1;
    #1 v = reg_rdata;
    tick();
    reg_rd = 0; store_evt = 0;
    check("R12 read returns old", v, 32'h1111_1111);
    flags(v); check("R12 store succeeds no err", v, 1);
    rd(2'd2, v); check("R12 new word", v, 32'h2222_2222);
  endtask

  task automatic t_frame();
    logic [W-1:0] v;
    wr(2'd0, 32'hE);
    wr(2'd1, 2);
    serial_in = 0; start_evt = 1; tick(); start_evt = 0;
    flags(v); check("R9 good start", v[1], 0);
    serial_in = 1; start_evt = 1; tick(); start_evt = 0;
    flags(v); check("R9 bad start", v[1], 1);
    wr(2'd1, 2);
    serial_in = 1; stop_evt = 1; tick(); stop_evt = 0;
    flags(v); check("R9 good stop", v[1], 0);
    serial_in = 0; stop_evt = 1; tick(); stop_evt = 0;
    flags(v); check("R9 bad stop", v[1], 1);
    wr(2'd1, 2);
    wr(2'd0, 2);
    serial_in = 1; start_evt = 1; tick(); start_evt = 0;
    serial_in = 0; stop_evt = 1; tick(); stop_evt = 0;
    flags(v); check("R9 checks disabled", v[1], 0);
  endtask

  task automatic t_match();
    logic [W-1:0] v;
    wr(2'd0, 3);
    wr(2'd2, 32'hBEEF_000F);
    shift_word(32'hBEE0_1234); store();
    flags(v); check("R8 masked match stores", v, 1);
    rd(2'd2, v); check("R8 matched word", v, 32'hBEE0_1234);
    wr(2'd2, 32'hBEEF_0000);
    shift_word(32'hBEE0_1234); store();
    flags(v); check("R8 mismatch no stat", v, 0);
    rd(2'd2, v); check("R8 mismatch buffer kept", v, 32'hBEEF_0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_transmit();
    t_collide_tx();
    t_irq_dma();
    t_receive();
    t_frame();
    t_match();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule